// File: doc/BRIEF.md
# Multi-Pipe Descriptor Fetch Arbiter with Group Locking

This block decides which pipe of a multi-pipe DMA engine may fetch its next descriptor. Every pipe keeps a count of descriptors that software has announced through event pulses. The arbiter offers one fetch at a time to the fetch unit, rotating fairly among the pipes that have work. It then waits for the fetched descriptor's type and flag bits before it offers the next fetch.

Command descriptors carry register operations rather than data. When such a descriptor has its lock flag set, the arbiter reserves fetching for the pipes that share the fetching pipe's group ID. All other pipes keep collecting events but are not served. A later command descriptor with the unlock flag restores normal rotation. The lock flag and the unlock flag have no effect on data descriptors.

Two status outputs show whether a lock is held and which group owns it. Each pipe's group ID is a static configuration input.

Top module: `desc_fetch_arb`

## Requirements
- R1: After reset, `fetch_req` is 0, `lock_held` is 0 and `lock_grp` is 0.
- R2: Each `evt_inc[i]` pulse adds one to pipe i's pending count, which saturates at 2^CNT_W-1. Each accepted grant (`fetch_req` and `fetch_gnt` high in the same cycle) removes one. `fetch_req` is 1 only while an eligible pipe has a pending count above zero.
- R3: Grants rotate round-robin, searching upward from the pipe after the last granted one. The first search after reset starts at pipe 0.
- R4: Only one fetch is outstanding at a time. After an accepted grant, `fetch_req` stays 0 until `desc_vld` returns that descriptor's flags.
- R5: A returned descriptor with `desc_cmd`=1 and `desc_lock`=1, arriving while no lock is held, sets `lock_held`=1. It also sets `lock_grp` to the group ID of the pipe that fetched it. Both take effect from the cycle after `desc_vld`.
- R6: While a lock is held, only pipes whose group ID (bits `pipe_grp_cfg[i*GRP_W +: GRP_W]`) equals `lock_grp` can be granted. Other pipes keep their pending counts and are served after the unlock.
- R7: A descriptor with `desc_cmd`=1 and `desc_unlock`=1 clears `lock_held`, sets `lock_grp` to 0, and restores round-robin over all pipes.
- R8: When `desc_cmd`=0, `desc_lock` and `desc_unlock` do not change the lock state.
- R9: A lock command while a lock is already held leaves `lock_held` and `lock_grp` unchanged. An unlock command while no lock is held leaves the arbiter unlocked and granting.
- R10: A command descriptor with both flags set is treated as lock first and unlock afterwards, so it leaves `lock_held`=0 and `lock_grp`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_inc | input | NUM_PIPES | Per-pipe pulse: one more descriptor pending |
| pipe_grp_cfg | input | NUM_PIPES*GRP_W | Group ID of each pipe, packed with pipe 0 at the LSBs |
| fetch_req | output | 1 | A descriptor fetch is offered |
| fetch_pipe | output | IDX_W | Pipe whose descriptor is offered |
| fetch_gnt | input | 1 | Fetch unit accepts the offered fetch |
| desc_vld | input | 1 | Fetched descriptor's flags are valid |
| desc_cmd | input | 1 | Descriptor is a command descriptor |
| desc_lock | input | 1 | Lock flag of the descriptor |
| desc_unlock | input | 1 | Unlock flag of the descriptor |
| lock_held | output | 1 | A group lock is active |
| lock_grp | output | GRP_W | Group that owns the lock (0 when none) |

## Verification
The bench builds the block with four pipes, two-bit group IDs and two-bit pending counters. Pipes 0 and 2 are in group 0, and pipes 1 and 3 are in group 1. With counters that small, saturation is reached after a few event pulses. The two groups of two pipes each let the bench check both sides of a lock: a group-mate is still served while the pipes of the other group wait with their pending counts intact. Four pipes also make rotation order visible across several sparse request patterns.

// File: rtl/desc_arb_pkg.sv
package desc_arb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_WAIT = 1'b1
  } arb_state_e;
endpackage

// File: rtl/pend_cnt.sv
module pend_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic             nonempty,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (inc && !dec && (cnt != CNT_MAX)) begin
      cnt_nxt = cnt + 1'b1;
    end else if (dec && !inc) begin
      cnt_nxt = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_nxt;
    end
  end

  assign nonempty = (cnt != '0);

  // Requirement R2: the counter saturates instead of wrapping to zero.
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && inc && !dec) |=> (cnt == CNT_MAX));
  // Requirement R2: a grant is never taken from an empty pipe.
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt != '0));
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] last,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = 1; k <= N; k++) begin
      if (!any && req[(int'(last) + k) % N]) begin
        any = 1'b1;
        idx = IDX_W'((int'(last) + k) % N);
      end
    end
  end
endmodule

// File: rtl/lock_ctl.sv
module lock_ctl #(
  parameter int GRP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic             is_cmd,
  input  logic             lk,
  input  logic             ul,
  input  logic [GRP_W-1:0] pipe_grp,
  output logic             held,
  output logic [GRP_W-1:0] grp
);
  logic             held_nxt;
  logic [GRP_W-1:0] grp_nxt;

  always_comb begin
    held_nxt = held;
    grp_nxt  = grp;
    if (upd && is_cmd) begin
      if (lk && !held) begin
        held_nxt = 1'b1;
        grp_nxt  = pipe_grp;
      end
      if (ul && held_nxt) begin
        held_nxt = 1'b0;
        grp_nxt  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      grp  <= '0;
    end else if (upd) begin
      held <= held_nxt;
      grp  <= grp_nxt;
    end
  end

  // Requirement R8: flags on data descriptors leave the lock untouched.
  assert_data_flags_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !is_cmd) |=> ($stable(held) && $stable(grp)));
  // Requirement R7: an unlock command always releases the lock.
  assert_unlock_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && is_cmd && ul) |=> !held);
  // Requirement R9: a second lock leaves the owner unchanged.
  assert_relock_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (held && upd && is_cmd && lk && !ul) |=> (held && $stable(grp)));
endmodule

// File: rtl/desc_fetch_arb.sv
module desc_fetch_arb
  import desc_arb_pkg::*;
#(
  parameter int NUM_PIPES = 4,
  parameter int GRP_W     = 2,
  parameter int CNT_W     = 4,
  localparam int IDX_W    = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PIPES-1:0]       evt_inc,
  input  logic [NUM_PIPES*GRP_W-1:0] pipe_grp_cfg,
  output logic                       fetch_req,
  output logic [IDX_W-1:0]           fetch_pipe,
  input  logic                       fetch_gnt,
  input  logic                       desc_vld,
  input  logic                       desc_cmd,
  input  logic                       desc_lock,
  input  logic                       desc_unlock,
  output logic                       lock_held,
  output logic [GRP_W-1:0]           lock_grp
);
  localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(NUM_PIPES - 1);

  arb_state_e       st, st_nxt;
  logic [IDX_W-1:0] cur_pipe, cur_pipe_nxt;
  logic [IDX_W-1:0] rr_last, rr_last_nxt;

  logic [GRP_W-1:0]     grp_arr [NUM_PIPES];
  logic [NUM_PIPES-1:0] nonempty;
  logic [NUM_PIPES-1:0] eligible;
  logic [NUM_PIPES-1:0] dec_vec;
  logic [CNT_W-1:0]     cnt_arr [NUM_PIPES];
  logic                 any_elig;
  logic                 take;
  logic                 upd;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PIPES; gi++) begin : g_pipe
      assign grp_arr[gi]  = pipe_grp_cfg[gi*GRP_W +: GRP_W];
      assign eligible[gi] = nonempty[gi] && (!lock_held || (grp_arr[gi] == lock_grp));
      assign dec_vec[gi]  = take && (fetch_pipe == IDX_W'(gi));

      pend_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (evt_inc[gi]),
        .dec      (dec_vec[gi]),
        .nonempty (nonempty[gi]),
        .cnt      (cnt_arr[gi])
      );
    end
  endgenerate

  rr_pick #(.N(NUM_PIPES), .IDX_W(IDX_W)) u_pick (
    .req  (eligible),
    .last (rr_last),
    .any  (any_elig),
    .idx  (fetch_pipe)
  );

  assign fetch_req = (st == ARB_IDLE) && any_elig;
  assign take      = fetch_req && fetch_gnt;
  assign upd       = (st == ARB_WAIT) && desc_vld;

  lock_ctl #(.GRP_W(GRP_W)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (upd),
    .is_cmd   (desc_cmd),
    .lk       (desc_lock),
    .ul       (desc_unlock),
    .pipe_grp (grp_arr[cur_pipe]),
    .held     (lock_held),
    .grp      (lock_grp)
  );

  always_comb begin
    st_nxt       = st;
    cur_pipe_nxt = cur_pipe;
    rr_last_nxt  = rr_last;
    unique case (st)
      ARB_IDLE: begin
        if (take) begin
          st_nxt       = ARB_WAIT;
          cur_pipe_nxt = fetch_pipe;
          rr_last_nxt  = fetch_pipe;
        end
      end
      ARB_WAIT: begin
        if (desc_vld) begin
          st_nxt = ARB_IDLE;
        end
      end
      default: st_nxt = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ARB_IDLE;
      cur_pipe <= '0;
      rr_last  <= LAST_INIT;
    end else begin
      st <= st_nxt;
      if (take) begin
        cur_pipe <= cur_pipe_nxt;
        rr_last  <= rr_last_nxt;
      end
    end
  end

  // Requirement R4: no second offer until the descriptor has returned.
  assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !fetch_req);
  // Requirement R6: under a lock only the owning group is offered.
  assert_locked_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && lock_held) |-> (grp_arr[fetch_pipe] == lock_grp));
  // Requirement R3: at most one pipe is charged per grant.
  assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_vec));
  // Requirement R2: an offered pipe always has work pending.
  assert_offer_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (cnt_arr[fetch_pipe] != '0));
endmodule

// File: tb/tb_desc_fetch_arb.sv
`timescale 1ns/1ps
module tb_desc_fetch_arb;
  localparam int NP    = 4;
  localparam int GW    = 2;
  localparam int CW    = 2;
  localparam int IW    = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] evt_inc = '0;
  // pipes 0,2 -> group 0 ; pipes 1,3 -> group 1
  logic [NP*GW-1:0] cfg = 8'b01_00_01_00;
  logic          fetch_req;
  logic [IW-1:0] fetch_pipe;
  logic          fetch_gnt = 1'b0;
  logic          desc_vld = 1'b0;
  logic          desc_cmd = 1'b0;
  logic          desc_lock = 1'b0;
  logic          desc_unlock = 1'b0;
  logic          lock_held;
  logic [GW-1:0] lock_grp;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  string tag_q[$];
  event gnt_ev;

  always #2 clk = ~clk;

  desc_fetch_arb #(.NUM_PIPES(NP), .GRP_W(GW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .evt_inc(evt_inc), .pipe_grp_cfg(cfg),
    .fetch_req(fetch_req), .fetch_pipe(fetch_pipe), .fetch_gnt(fetch_gnt),
    .desc_vld(desc_vld), .desc_cmd(desc_cmd), .desc_lock(desc_lock),
    .desc_unlock(desc_unlock), .lock_held(lock_held), .lock_grp(lock_grp)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected pipe for each accepted grant.
  initial begin
    forever begin
      @(gnt_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected grant", int'(fetch_pipe), -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(fetch_pipe == IW'(e), t, int'(fetch_pipe), e);
      end
    end
  end

  task automatic post(input logic [NP-1:0] mask);
    @(negedge clk);
    evt_inc = mask;
    @(negedge clk);
    evt_inc = '0;
  endtask

  task automatic fetch(input int exp, input bit cmd, input bit lk, input bit ul,
                       input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    do @(negedge clk); while (!fetch_req);
    fetch_gnt = 1'b1;
    #1;
    -> gnt_ev;
    @(negedge clk);
    fetch_gnt = 1'b0;
    check(fetch_req == 1'b0, "R4 request while outstanding", int'(fetch_req), 0);
    desc_vld = 1'b1;
    desc_cmd = cmd;
    desc_lock = lk;
    desc_unlock = ul;
    @(negedge clk);
    desc_vld = 1'b0;
    desc_cmd = 1'b0;
    desc_lock = 1'b0;
    desc_unlock = 1'b0;
  endtask

  task automatic chk_lock(input bit h, input int g, input string tag);
    check(lock_held == h, {tag, " lock_held"}, int'(lock_held), int'(h));
    check(lock_grp == GW'(g), {tag, " lock_grp"}, int'(lock_grp), g);
  endtask

  task automatic chk_idle(input string tag);
    @(negedge clk);
    check(fetch_req == 1'b0, tag, int'(fetch_req), 0);
  endtask

  initial begin
    #(4 * 100000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(fetch_req == 1'b0, "R1 fetch_req after reset", int'(fetch_req), 0);
    chk_lock(1'b0, 0, "R1");

    // R3 all pipes pending: rotation starts at pipe 0
    post(4'b1111);
    fetch(0, 0, 0, 0, "R3 full rotation p0");
    fetch(1, 0, 0, 0, "R3 full rotation p1");
    fetch(2, 0, 0, 0, "R3 full rotation p2");
    fetch(3, 0, 0, 0, "R3 full rotation p3");
    chk_idle("R2 no request when empty");

    // R3 sparse pattern after last=3
    post(4'b0101);
    fetch(0, 0, 0, 0, "R3 sparse p0");
    fetch(2, 0, 0, 0, "R3 sparse p2");

    // R5 lock by pipe 1 (group 1)
    post(4'b0010);
    fetch(1, 1, 1, 0, "R5 lock cmd p1");
    chk_lock(1'b1, 1, "R5");
    post(4'b1111);
    fetch(3, 0, 0, 1, "R6 group mate p3");
    chk_lock(1'b1, 1, "R8 data unlock ignored");
    fetch(1, 0, 0, 0, "R6 owner p1");
    chk_idle("R6 other group blocked");
    post(4'b1000);
    fetch(3, 1, 1, 0, "R9 relock p3");
    chk_lock(1'b1, 1, "R9 relock no-op");
    post(4'b0010);
    fetch(1, 1, 0, 1, "R7 unlock cmd p1");
    chk_lock(1'b0, 0, "R7");
    fetch(2, 0, 0, 0, "R6 kept pending p2");
    fetch(0, 0, 0, 0, "R6 kept pending p0");

    // R8 lock flag on data descriptor
    post(4'b0001);
    fetch(0, 0, 1, 0, "R8 data lock p0");
    chk_lock(1'b0, 0, "R8 data lock ignored");

    // R9 unlock with nothing held
    post(4'b0100);
    fetch(2, 1, 0, 1, "R9 stray unlock p2");
    chk_lock(1'b0, 0, "R9 stray unlock");
    post(4'b1000);
    fetch(3, 0, 0, 0, "R9 grants continue p3");

    // R10 both flags
    post(4'b0010);
    fetch(1, 1, 1, 1, "R10 lock+unlock p1");
    chk_lock(1'b0, 0, "R10");
    post(4'b0101);
    fetch(2, 0, 0, 0, "R10 resume p2");
    fetch(0, 0, 0, 0, "R10 resume p0");

    // R2 saturation at 3
    repeat (5) post(4'b0001);
    fetch(0, 0, 0, 0, "R2 sat fetch 1");
    fetch(0, 0, 0, 0, "R2 sat fetch 2");
    fetch(0, 0, 0, 0, "R2 sat fetch 3");
    chk_idle("R2 saturated count drained");

    // R5/R6 lock by group 0
    post(4'b0100);
    fetch(2, 1, 1, 0, "R5 lock cmd p2");
    chk_lock(1'b1, 0, "R5 group0");
    post(4'b1111);
    fetch(0, 0, 0, 0, "R6 grp0 p0");
    fetch(2, 0, 0, 0, "R6 grp0 p2");
    chk_idle("R6 group1 blocked");
    post(4'b0001);
    fetch(0, 1, 0, 1, "R7 unlock p0");
    chk_lock(1'b0, 0, "R7 group0 release");
    fetch(1, 0, 0, 0, "R7 released p1");
    fetch(3, 0, 0, 0, "R7 released p3");
    chk_idle("R2 all drained");

    check(exp_q.size() == 0, "R3 grants missing", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule